// File: doc/BRIEF.md
# Selectable-Rate Digital Quadrature Mixer

This block moves a pair of already-interpolated I/Q sample streams up or down in frequency by a fixed fraction of the output sample rate. The shift can be zero, fs/2, fs/4 or fs/8. It works at the high output rate and places each sample on an eight-point phase circle, with 45 degrees between points. A 3-bit phase index moves forward by 0, 4, 2 or 1 points each time a valid sample arrives.

Two operating styles are available. In real style, each channel is scaled on its own by the cosine sequence, with no cross terms between I and Q. In complex style, the two channels are combined into one complex product of (I + jQ) and a rotating phasor. A direction input chooses whether the phasor turns clockwise or anticlockwise, which selects the image that an analog quadrature modulator further down the chain will suppress. The coefficients use a signed format with 14 fraction bits. Each result is rounded back to the sample width and clipped if it overflows. Output samples appear two clock cycles after their inputs, and the valid strobe is delayed by the same amount.

Top module: `qmix_top`

## Requirements
- R1: The rate code selects the phase step per valid sample: 2'b00 gives step 0 (phase stays 0, samples pass through unchanged), 2'b01 gives fs/2 (step 4), 2'b10 gives fs/4 (step 2) and 2'b11 gives fs/8 (step 1). Phase p stands for the angle p*45 degrees.
- R2: The phase index advances only in cycles where in_valid is 1. It holds while in_valid is 0 and the rate code is unchanged.
- R3: In any cycle where the rate code differs from its value in the previous cycle, the phase index restarts at 0. A valid sample in that cycle uses phase 0.
- R4: With cplx_en = 0, out_i = round(in_i*cos) and out_q = round(in_q*cos). There are no cross terms.
- R5: With cplx_en = 1 and rot_dir = 0 (clockwise rotation, e^-jwt), out_i = round(I*cos + Q*sin) and out_q = round(Q*cos - I*sin).
- R6: With cplx_en = 1 and rot_dir = 1 (anticlockwise rotation, e^+jwt), out_i = round(I*cos - Q*sin) and out_q = round(Q*cos + I*sin).
- R7: Coefficients use 14 fraction bits. Unity is 16384, and the 45-degree magnitude is 11585. Rounding adds 8192 and then shifts right arithmetically by 14.
- R8: A rounded result above 32767 is clipped to 32767, and one below -32768 is clipped to -32768.
- R9: out_valid follows in_valid by exactly two cycles. Each output sample appears two cycles after its input. Outputs hold their last value between valid samples. Reset clears out_valid, out_i and out_q to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Signed in-phase sample |
| in_q | input | 16 | Signed quadrature sample |
| rate | input | 2 | Shift-rate code (none, fs/2, fs/4, fs/8) |
| cplx_en | input | 1 | 1 = coupled complex rotation, 0 = independent real scaling |
| rot_dir | input | 1 | 0 = clockwise (e^-jwt), 1 = anticlockwise (e^+jwt) |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Signed mixed in-phase sample |
| out_q | output | 16 | Signed mixed quadrature sample |

## Verification
The properties assume that rate, cplx_en and rot_dir are real binary values on every clock after reset, and that in_valid is never X. The latency and no-cross-term properties also assume that no reset falls between a sample and its result. The stimulus changes every control input only at the falling edge and never leaves any of them undriven. It keeps rst_n high from release until the end of the run. The bench also switches the rate both in a cycle that carries a sample and in an idle cycle, so the phase-restart assumption is exercised on both sides.

// File: rtl/qmix_pkg.sv
package qmix_pkg;

  typedef enum logic [1:0] {
    RATE_NONE    = 2'b00,
    RATE_HALF    = 2'b01,
    RATE_QUARTER = 2'b10,
    RATE_EIGHTH  = 2'b11
  } rate_e;

  // phase increment on the eight-point circle for each rate code (R1)
  function automatic logic [2:0] rate_step(rate_e r);
    case (r)
      RATE_HALF:    return 3'd4;
      RATE_QUARTER: return 3'd2;
      RATE_EIGHTH:  return 3'd1;
      default:      return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/qmix_phase.sv
module qmix_phase
  import qmix_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           rate,
  output logic signed [CW-1:0] cos_o,
  output logic signed [CW-1:0] sin_o
);

  localparam int UNITY = 1 << (CW - 2);
  localparam int DIAG  = int'(0.70710678 * UNITY);
  localparam logic signed [CW-1:0] K1 = CW'(UNITY);
  localparam logic signed [CW-1:0] KD = CW'(DIAG);

  logic [1:0] rate_q;
  logic [2:0] ph_q, ph_d, ph_eff;
  logic       rate_chg;

  always_comb begin
    rate_chg = (rate != rate_q);
    ph_eff   = rate_chg ? 3'd0 : ph_q;
    ph_d     = in_valid ? ph_eff + rate_step(rate_e'(rate)) : ph_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= 2'b00;
      ph_q   <= 3'd0;
    end else begin
      rate_q <= rate;
      ph_q   <= ph_d;
    end
  end

  always_comb begin
    case (ph_eff)
      3'd0:    begin cos_o =  K1; sin_o = '0;  end
      3'd1:    begin cos_o =  KD; sin_o =  KD; end
      3'd2:    begin cos_o = '0;  sin_o =  K1; end
      3'd3:    begin cos_o = -KD; sin_o =  KD; end
      3'd4:    begin cos_o = -K1; sin_o = '0;  end
      3'd5:    begin cos_o = -KD; sin_o = -KD; end
      3'd6:    begin cos_o = '0;  sin_o = -K1; end
      default: begin cos_o =  KD; sin_o = -KD; end
    endcase
  end

  // R1: the stored phase stays on the grid of the active rate
  p_grid_none_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == 2'b00) |-> (ph_q == 3'd0));
  p_grid_half_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == 2'b01) |-> (ph_q[1:0] == 2'b00));
  p_grid_quarter_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == 2'b10) |-> !ph_q[0]);
  // R2: no movement without a sample
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && rate == rate_q) |=> $stable(ph_q));
  // R3: a rate change lands on phase zero
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rate != rate_q) |-> (cos_o == K1 && sin_o == '0));

endmodule

// File: rtl/qmix_prod.sv
module qmix_prod #(
  parameter int DW = 16,
  parameter int CW = 16,
  localparam int PW = DW + CW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic signed [CW-1:0] cos_c,
  input  logic signed [CW-1:0] sin_c,
  input  logic                 cplx_en,
  input  logic                 rot_dir,
  output logic                 v_o,
  output logic signed [PW-1:0] p_ic,
  output logic signed [PW-1:0] p_qs,
  output logic signed [PW-1:0] p_qc,
  output logic signed [PW-1:0] p_is,
  output logic                 cplx_o,
  output logic                 dir_o
);

  logic signed [PW-1:0] ic_d, qs_d, qc_d, is_d;

  always_comb begin
    ic_d = PW'(in_i) * PW'(cos_c);
    qs_d = PW'(in_q) * PW'(sin_c);
    qc_d = PW'(in_q) * PW'(cos_c);
    is_d = PW'(in_i) * PW'(sin_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o    <= 1'b0;
      p_ic   <= '0;
      p_qs   <= '0;
      p_qc   <= '0;
      p_is   <= '0;
      cplx_o <= 1'b0;
      dir_o  <= 1'b0;
    end else begin
      v_o <= in_valid;
      if (in_valid) begin
        p_ic   <= ic_d;
        p_qs   <= qs_d;
        p_qc   <= qc_d;
        p_is   <= is_d;
        cplx_o <= cplx_en;
        dir_o  <= rot_dir;
      end
    end
  end

endmodule

// File: rtl/qmix_out.sv
module qmix_out #(
  parameter int DW = 16,
  parameter int CW = 16,
  localparam int PW = DW + CW,
  localparam int SW = PW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_i,
  input  logic signed [PW-1:0] p_ic,
  input  logic signed [PW-1:0] p_qs,
  input  logic signed [PW-1:0] p_qc,
  input  logic signed [PW-1:0] p_is,
  input  logic                 cplx_i,
  input  logic                 dir_i,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);

  localparam logic signed [SW-1:0] HALF = SW'(1) <<< (CW - 3);
  localparam logic signed [SW-1:0] HI   = (SW'(1) <<< (DW - 1)) - SW'(1);
  localparam logic signed [SW-1:0] LO   = -(SW'(1) <<< (DW - 1));

  logic signed [SW-1:0] si, sq, ri, rq;
  logic signed [DW-1:0] oi_d, oq_d;

  function automatic logic signed [DW-1:0] clip(logic signed [SW-1:0] x);
    if (x > HI)      return DW'(HI);
    else if (x < LO) return DW'(LO);
    else             return DW'(x);
  endfunction

  always_comb begin
    if (cplx_i) begin
      si = dir_i ? SW'(p_ic) - SW'(p_qs) : SW'(p_ic) + SW'(p_qs);
      sq = dir_i ? SW'(p_qc) + SW'(p_is) : SW'(p_qc) - SW'(p_is);
    end else begin
      si = SW'(p_ic);
      sq = SW'(p_qc);
    end
    ri   = (si + HALF) >>> (CW - 2);
    rq   = (sq + HALF) >>> (CW - 2);
    oi_d = clip(ri);
    oq_d = clip(rq);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= v_i;
      if (v_i) begin
        out_i <= oi_d;
        out_q <= oq_d;
      end
    end
  end

  // R9: outputs hold between samples
  p_hold_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !v_i |=> ($stable(out_i) && $stable(out_q)));

endmodule

// File: rtl/qmix_top.sv
module qmix_top #(
  parameter int DW = 16,
  parameter int CW = 16,
  localparam int PW = DW + CW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic [1:0]           rate,
  input  logic                 cplx_en,
  input  logic                 rot_dir,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);

  logic signed [CW-1:0] cos_c, sin_c;
  logic signed [PW-1:0] p_ic, p_qs, p_qc, p_is;
  logic                 v1, cplx1, dir1;

  qmix_phase #(.CW(CW)) u_phase (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rate(rate),
    .cos_o(cos_c), .sin_o(sin_c)
  );

  qmix_prod #(.DW(DW), .CW(CW)) u_prod (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .cos_c(cos_c), .sin_c(sin_c), .cplx_en(cplx_en), .rot_dir(rot_dir),
    .v_o(v1), .p_ic(p_ic), .p_qs(p_qs), .p_qc(p_qc), .p_is(p_is),
    .cplx_o(cplx1), .dir_o(dir1)
  );

  qmix_out #(.DW(DW), .CW(CW)) u_out (
    .clk(clk), .rst_n(rst_n), .v_i(v1), .p_ic(p_ic), .p_qs(p_qs),
    .p_qc(p_qc), .p_is(p_is), .cplx_i(cplx1), .dir_i(dir1),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  // R9: two-cycle strobe latency
  p_lat_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  p_lat_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);
  // R4: real style keeps channels apart, so a zero I input yields zero I output
  p_no_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cplx_en && in_i == '0) |-> ##2 (out_i == '0));

endmodule

// File: tb/sim_qmix_top.sv
module sim_qmix_top;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, cplx_en, rot_dir;
  logic signed [15:0] in_i, in_q;
  logic [1:0] rate;
  logic out_valid;
  logic signed [15:0] out_i, out_q;

  always #5 clk = ~clk;

  qmix_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .rate(rate), .cplx_en(cplx_en), .rot_dir(rot_dir),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int n_vec = 0, n_bad = 0;
  // reference state
  int m_rate_prev = 0, m_ph = 0;
  logic pv0 = 0, pv1 = 0;
  int pi0 = 0, pi1 = 0, pq0 = 0, pq1 = 0, hold_i = 0, hold_q = 0;
  string pt0 = "R9", pt1 = "R9", tag = "R9";

  function automatic int sat16(longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return int'(x);
  endfunction

  function automatic int qcoef(real ang);
    return int'(ang * 16384.0);
  endfunction

  // behavioural reference for one input cycle
  task automatic model(input logic v, input int i, input int q, input int r,
                       input logic cx, input logic dr);
    int ph, stp, c, s;
    longint si, sq;
    real a;
    ph = (r != m_rate_prev) ? 0 : m_ph;
    stp = (r == 1) ? 4 : (r == 2) ? 2 : (r == 3) ? 1 : 0;
    pv0 = v;
    pt0 = tag;
    if (v) begin
      a = 3.14159265358979 * ph / 4.0;
      c = qcoef($cos(a));
      s = qcoef($sin(a));
      if (cx) begin
        si = longint'(i) * c + (dr ? -longint'(q) * s : longint'(q) * s);
        sq = longint'(q) * c + (dr ? longint'(i) * s : -longint'(i) * s);
      end else begin
        si = longint'(i) * c;
        sq = longint'(q) * c;
      end
      pi0 = sat16((si + 8192) >>> 14);
      pq0 = sat16((sq + 8192) >>> 14);
      m_ph = (ph + stp) % 8;
    end else begin
      m_ph = ph;
    end
    m_rate_prev = r;
  endtask

  task automatic check();
    if (pv1) begin hold_i = pi1; hold_q = pq1; end
    n_vec++;
    if (out_valid !== pv1 || int'(out_i) != hold_i || int'(out_q) != hold_q) begin
      n_bad++;
      $display("FAIL %s: actual v=%0b i=%0d q=%0d expected v=%0b i=%0d q=%0d",
               pt1, out_valid, out_i, out_q, pv1, hold_i, hold_q);
    end
  endtask

  task automatic step(input logic v, input int i, input int q, input int r,
                      input logic cx, input logic dr);
    @(negedge clk);
    check();
    pv1 = pv0; pi1 = pi0; pq1 = pq0; pt1 = pt0;
    in_valid = v; in_i = 16'(i); in_q = 16'(q); rate = 2'(r);
    cplx_en = cx; rot_dir = dr;
    if (rst_n) model(v, i, q, r, cx, dr);
    else begin pv0 = 1'b0; pt0 = tag; end
  endtask

  function automatic int rnd();
    return int'($urandom_range(65535)) - 32768;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(7));
    rst_n = 1'b0; in_valid = 0; in_i = 0; in_q = 0; rate = 0; cplx_en = 0; rot_dir = 0;
    // R9: reset state of outputs
    tag = "R9";
    repeat (4) step(0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    // R1: pass-through at code 00, including both extremes
    tag = "R1";
    repeat (5) step(1, rnd(), rnd(), 0, 0, 0);
    step(1, -32768, 32767, 0, 0, 0);
    step(1, 32767, -32768, 0, 0, 0);
    // R4: real style at each nonzero rate
    tag = "R4";
    repeat (6)  step(1, rnd(), rnd(), 1, 0, 0);
    repeat (8)  step(1, rnd(), rnd(), 2, 0, 0);
    repeat (16) step(1, rnd(), rnd(), 3, 0, 0);
    // R2: gaps in the valid strobe
    tag = "R2";
    for (int k = 0; k < 15; k++) step(k % 3 != 0, rnd(), rnd(), 3, 0, 0);
    // R3: rate change with a sample, then during an idle cycle
    tag = "R3";
    repeat (4) step(1, rnd(), rnd(), 2, 0, 0);
    step(0, 0, 0, 3, 0, 0);
    repeat (4) step(1, rnd(), rnd(), 3, 0, 0);
    step(1, 1000, -2000, 1, 0, 0);
    step(1, 1000, -2000, 1, 0, 0);
    // R5: complex style, clockwise
    tag = "R5";
    repeat (16) step(1, rnd(), rnd(), 3, 1, 0);
    repeat (8)  step(1, rnd(), rnd(), 2, 1, 0);
    // R6: complex style, anticlockwise
    tag = "R6";
    repeat (16) step(1, rnd(), rnd(), 3, 1, 1);
    repeat (4)  step(1, rnd(), rnd(), 1, 1, 1);
    // R7: small values exercise rounding at the 45 degree points
    tag = "R7";
    for (int k = 0; k < 16; k++) step(1, k - 8, 7 - k, 3, 0, 0);
    for (int k = 0; k < 8; k++)  step(1, 3 * k - 10, k, 3, 1, k % 2);
    // R8: clipping in complex and real styles
    tag = "R8";
    step(0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 8; k++) step(1, 32767, 32767, 3, 1, 0);
    for (int k = 0; k < 8; k++) step(1, -32768, -32768, 3, 1, 1);
    for (int k = 0; k < 4; k++) step(1, -32768, -32768, 1, 0, 0);
    // R9: drain and confirm outputs hold
    tag = "R9";
    repeat (4) step(0, 0, 0, 1, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule